// File: doc/BRIEF.md
# Boot Entry Erase and Handoff Sequencer

This block runs once, when the device leaves reset with its boot-mode strap set. It scans the on-chip flash one word at a time to find out whether the flash is blank. A word counts as blank only when every bit reads as 1. The scan stops at the first word that holds a 0 bit. If that happens, the block erases every flash block in ascending order. A blank device skips the erase completely.

After the flash work it prepares the serial channel that carried the download. It clears that channel's receive and transmit enables and keeps the baud-rate value. It then makes the transmit pin an output at high level. Finally it issues a one-cycle branch request that carries a fixed RAM entry address for the loader, and raises a done flag that stays set until reset. Interrupts are masked for as long as erase work is active. The block touches no other on-chip registers.

If boot mode is not set in the first cycle after reset, the block stays idle until the next reset.

Top module: `boot_handoff_seq`

## Requirements
- R1: While reset is applied, all of these outputs are 0: rd_valid, er_start, sci_re, sci_te, baud_keep, txd_oe, txd_out, irq_mask, branch_req and done.
- R2: If boot_mode is low in the first cycle after reset, the block issues no read and no erase. It leaves the serial enables low and never raises branch_req or done.
- R3: The scan reads word addresses 0, 1, 2 and so on, with one request at a time. A request is accepted in a cycle where rd_valid and rd_ready are both high, and rd_addr is held until then. A response is one cycle of rsp_valid with rsp_data. The scan stops at the first response that is not all ones. A blank device takes exactly NUM_WORDS reads.
- R4: When every scanned word is all ones, er_start never rises.
- R5: When a word that is not all ones is found, er_start pulses for one cycle per block. The er_blk values run 0 up to NUM_BLOCKS-1. The first pulse comes one cycle after the cycle in which the deciding response was presented. Each later pulse comes only after er_done has been seen for the previous block.
- R6: irq_mask is high from the cycle of the first er_start through the cycle in which the last er_done is presented, and low at all other times.
- R7: sci_re and sci_te both go high after the scan starts. Both go low two cycles after the final event is presented. The final event is the last erase done when an erase runs, and otherwise the last scan response.
- R8: baud_keep goes high when the scan starts and never goes low again before reset.
- R9: txd_oe and txd_out both go high one cycle after the serial enables drop, and they stay high.
- R10: branch_req is high for exactly one cycle, one cycle after the transmit pin goes high. branch_addr equals BRANCH_TARGET, which defaults to 16'hE088. done rises in the same cycle as branch_req and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Boot-mode strap, sampled in the first cycle after reset |
| rd_valid | output | 1 | Flash read request valid |
| rd_addr | output | ADDR_W | Flash word address of the request |
| rd_ready | input | 1 | Flash accepts the request |
| rsp_valid | input | 1 | Read response valid, one cycle |
| rsp_data | input | DATA_W | Read response word |
| er_start | output | 1 | One-cycle erase command for block er_blk |
| er_blk | output | BLK_W | Index of the block to erase |
| er_done | input | 1 | Erase of the commanded block finished |
| sci_re | output | 1 | Serial receive enable |
| sci_te | output | 1 | Serial transmit enable |
| baud_keep | output | 1 | Keep the adjusted baud-rate value in its register |
| txd_oe | output | 1 | Transmit pin output enable |
| txd_out | output | 1 | Transmit pin output level |
| irq_mask | output | 1 | Interrupt mask while erase is active |
| branch_req | output | 1 | One-cycle branch request to the loader |
| branch_addr | output | TGT_W | Loader entry address |
| done | output | 1 | Handoff complete, held until reset |

## Verification
The bench drives flash responses and erase-done pulses at falling edges and numbers every falling edge. All timing is therefore measured from the edge at which the deciding event was presented. The checks expect:
- the first erase command one edge after the deciding response;
- the serial enables down two edges after the final event;
- the transmit pin high three edges after it;
- the branch pulse four edges after it.

The width of the interrupt mask is checked as an exact count of edges, from the first erase command to the last erase done. Read addresses and erase block indices are compared with a running count at the moment each handshake is seen. All of these checks are repeated across every position of the first programmed word, a blank device, and three flash ready patterns.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ERASE,
        ST_QUIESCE,
        ST_DRIVE,
        ST_BRANCH,
        ST_DONE,
        ST_OFF
    } seq_state_t;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_ISSUE,
        SC_WAIT
    } scan_state_t;

    typedef enum logic [1:0] {
        ER_IDLE,
        ER_PULSE,
        ER_WAIT
    } erase_state_t;

    typedef struct packed {
        logic done;
        logic blank;
    } scan_result_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic baud_keep;
        logic txd_oe;
        logic txd_lvl;
    } serial_pins_t;

    localparam logic [15:0] DEFAULT_LOADER_ENTRY = 16'hE088;

    function automatic seq_state_t state_after_scan(input scan_result_t r);
        return r.blank ? ST_QUIESCE : ST_ERASE;
    endfunction

endpackage

// File: rtl/scan_unit.sv
module scan_unit
    import boot_seq_pkg::*;
#(
    parameter int NUM_WORDS = 1024,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output scan_result_t      res
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

    scan_state_t       st;
    logic [ADDR_W-1:0] idx;
    logic              hit;
    logic              dirty;

    always_comb begin
        rd_valid  = (st == SC_ISSUE);
        rd_addr   = idx;
        hit       = (st == SC_WAIT) && rsp_valid;
        dirty     = hit && !(&rsp_data);
        res.done  = hit && (dirty || (idx == LAST_IDX));
        res.blank = hit && !dirty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SC_IDLE;
            idx <= '0;
        end else begin
            case (st)
                SC_IDLE: begin
                    if (start) begin
                        idx <= '0;
                        st  <= SC_ISSUE;
                    end
                end
                SC_ISSUE: begin
                    if (rd_ready) st <= SC_WAIT;
                end
                SC_WAIT: begin
                    if (hit) begin
                        if (res.done) begin
                            st <= SC_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SC_ISSUE;
                        end
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    // R3: a request that is not yet accepted keeps its address
    a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R3: after an all-ones word that is not the last, the next address follows
    a_r3_next_address: assert property (@(posedge clk) disable iff (rst)
        (hit && !res.done) |=> (rd_valid && rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

endmodule

// File: rtl/erase_unit.sv
module erase_unit
    import boot_seq_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             er_start,
    output logic [BLK_W-1:0] er_blk,
    input  logic             er_done,
    output logic             busy,
    output logic             fin
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    erase_state_t     st;
    logic [BLK_W-1:0] blk;
    logic             step;

    always_comb begin
        er_start = (st == ER_PULSE);
        er_blk   = blk;
        busy     = (st != ER_IDLE);
        step     = (st == ER_WAIT) && er_done;
        fin      = step && (blk == LAST_BLK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ER_IDLE;
            blk <= '0;
        end else begin
            case (st)
                ER_IDLE: begin
                    if (start) begin
                        blk <= '0;
                        st  <= ER_PULSE;
                    end
                end
                ER_PULSE: st <= ER_WAIT;
                ER_WAIT: begin
                    if (fin) begin
                        st <= ER_IDLE;
                    end else if (step) begin
                        blk <= blk + 1'b1;
                        st  <= ER_PULSE;
                    end
                end
                default: st <= ER_IDLE;
            endcase
        end
    end

    // R5: each erase command lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        er_start |=> !er_start);

    // R5: no new command while the current block is unfinished
    a_r5_wait_for_done: assert property (@(posedge clk) disable iff (rst)
        ((st == ER_WAIT) && !er_done) |=> !er_start);

    // R5: blocks are taken in ascending order
    a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
        (step && !fin) |=> (er_start && er_blk == BLK_W'($past(er_blk) + 1'b1)));

endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import boot_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  seq_state_t   st,
    output serial_pins_t pins,
    output logic         branch_req,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins       <= '0;
            branch_req <= 1'b0;
            done       <= 1'b0;
        end else begin
            branch_req <= 1'b0;
            case (st)
                ST_SCAN: begin
                    pins.rx_en     <= 1'b1;
                    pins.tx_en     <= 1'b1;
                    pins.baud_keep <= 1'b1;
                end
                ST_QUIESCE: begin
                    pins.rx_en <= 1'b0;
                    pins.tx_en <= 1'b0;
                end
                ST_DRIVE: begin
                    pins.txd_oe  <= 1'b1;
                    pins.txd_lvl <= 1'b1;
                end
                ST_BRANCH: begin
                    branch_req <= 1'b1;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R8: the baud value is never released once kept
    a_r8_baud_kept: assert property (@(posedge clk) disable iff (rst)
        pins.baud_keep |=> pins.baud_keep);

    // R9: the transmit pin turns on only with the serial enables already off
    a_r9_txd_after_quiesce: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.txd_oe) |-> (!pins.rx_en && !pins.tx_en && pins.txd_lvl));

    // R10: done is sticky and branch_req is one cycle
    a_r10_done_held: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r10_branch_once: assert property (@(posedge clk) disable iff (rst)
        branch_req |=> !branch_req);

endmodule

// File: rtl/boot_handoff_seq.sv
module boot_handoff_seq
    import boot_seq_pkg::*;
#(
    parameter int              NUM_WORDS     = 1024,
    parameter int              DATA_W        = 32,
    parameter int              NUM_BLOCKS    = 16,
    parameter int              TGT_W         = 16,
    parameter logic [TGT_W-1:0] BRANCH_TARGET = TGT_W'(DEFAULT_LOADER_ENTRY),
    localparam int             ADDR_W        = $clog2(NUM_WORDS),
    localparam int             BLK_W         = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              er_start,
    output logic [BLK_W-1:0]  er_blk,
    input  logic              er_done,
    output logic              sci_re,
    output logic              sci_te,
    output logic              baud_keep,
    output logic              txd_oe,
    output logic              txd_out,
    output logic              irq_mask,
    output logic              branch_req,
    output logic [TGT_W-1:0]  branch_addr,
    output logic              done
);
    seq_state_t   st;
    scan_result_t scan_res;
    serial_pins_t pins;
    logic         scan_go;
    logic         erase_go;
    logic         erase_busy;
    logic         erase_fin;

    always_comb begin
        scan_go  = (st == ST_IDLE) && boot_mode;
        erase_go = (st == ST_SCAN) && scan_res.done && !scan_res.blank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:    st <= boot_mode ? ST_SCAN : ST_OFF;
                ST_SCAN:    if (scan_res.done) st <= state_after_scan(scan_res);
                ST_ERASE:   if (erase_fin) st <= ST_QUIESCE;
                ST_QUIESCE: st <= ST_DRIVE;
                ST_DRIVE:   st <= ST_BRANCH;
                ST_BRANCH:  st <= ST_DONE;
                ST_DONE:    st <= ST_DONE;
                default:    st <= ST_OFF;
            endcase
        end
    end

    scan_unit #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (scan_go),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_ready  (rd_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .res       (scan_res)
    );

    erase_unit #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_erase (
        .clk      (clk),
        .rst      (rst),
        .start    (erase_go),
        .er_start (er_start),
        .er_blk   (er_blk),
        .er_done  (er_done),
        .busy     (erase_busy),
        .fin      (erase_fin)
    );

    port_ctrl u_port (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .pins       (pins),
        .branch_req (branch_req),
        .done       (done)
    );

    assign sci_re      = pins.rx_en;
    assign sci_te      = pins.tx_en;
    assign baud_keep   = pins.baud_keep;
    assign txd_oe      = pins.txd_oe;
    assign txd_out     = pins.txd_lvl;
    assign irq_mask    = (st == ST_ERASE);
    assign branch_addr = BRANCH_TARGET;

    // R6: every erase command is issued under the interrupt mask
    a_r6_mask_covers_erase: assert property (@(posedge clk) disable iff (rst)
        er_start |-> irq_mask);

    // R6: the mask is held only while the eraser is working
    a_r6_mask_needs_erase: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> erase_busy);

    // R4: a blank scan result never leads to erase
    a_r4_blank_no_erase: assert property (@(posedge clk) disable iff (rst)
        (scan_res.done && scan_res.blank) |=> !er_start);

    // R7: the branch leaves with the serial enables cleared
    a_r7_serial_off_at_branch: assert property (@(posedge clk) disable iff (rst)
        branch_req |-> (!sci_re && !sci_te && baud_keep));

    // R2: without boot mode nothing is requested
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OFF) |-> (!rd_valid && !er_start && !done));

endmodule

// File: tb/boot_handoff_seq_bench.sv
module boot_handoff_seq_bench;
    localparam int NW = 8;
    localparam int DW = 8;
    localparam int NB = 4;
    localparam int AW = $clog2(NW);
    localparam int BW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_mode = 1'b0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic          rd_ready = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          er_start;
    logic [BW-1:0] er_blk;
    logic          er_done = 1'b0;
    logic          sci_re, sci_te, baud_keep, txd_oe, txd_out, irq_mask;
    logic          branch_req, done;
    logic [15:0]   branch_addr;

    boot_handoff_seq #(
        .NUM_WORDS(NW), .DATA_W(DW), .NUM_BLOCKS(NB), .TGT_W(16)
    ) u_boot_handoff_seq (
        .clk(clk), .rst(rst), .boot_mode(boot_mode),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .er_start(er_start), .er_blk(er_blk), .er_done(er_done),
        .sci_re(sci_re), .sci_te(sci_te), .baud_keep(baud_keep),
        .txd_oe(txd_oe), .txd_out(txd_out), .irq_mask(irq_mask),
        .branch_req(branch_req), .branch_addr(branch_addr), .done(done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    logic [DW-1:0] fl [NW];
    int rdy_mode;
    int ncyc, n_reads, n_erases, er_cnt, pend_addr;
    bit pend;
    int last_rsp_cyc, first_er_cyc, last_done_cyc, irq_cycles;
    int en_cyc, fall_cyc, txd_cyc, br_cyc, br_count;
    bit done_seen, done_drop, baud_seen, baud_drop, txd_drop;
    int bad_addr, bad_blk, bad_overlap, bad_target;

    always @(negedge clk) begin
        if (rst) begin
            ncyc = 0; n_reads = 0; n_erases = 0; er_cnt = 0; pend = 0; pend_addr = 0;
            last_rsp_cyc = -1; first_er_cyc = -1; last_done_cyc = -1; irq_cycles = 0;
            en_cyc = -1; fall_cyc = -1; txd_cyc = -1; br_cyc = -1; br_count = 0;
            done_seen = 0; done_drop = 0; baud_seen = 0; baud_drop = 0; txd_drop = 0;
            bad_addr = 0; bad_blk = 0; bad_overlap = 0; bad_target = 0;
            rsp_valid = 0; er_done = 0; rd_ready = 0;
        end else begin
            ncyc++;
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_data = fl[pend_addr];
                pend = 0;
                last_rsp_cyc = ncyc;
            end else begin
                rsp_valid = 1'b0;
            end
            case (rdy_mode)
                0: rd_ready = 1'b1;
                1: rd_ready = (ncyc % 2) == 0;
                default: rd_ready = (ncyc % 3) == 0;
            endcase
            if (rd_valid && rd_ready) begin
                if (int'(rd_addr) != n_reads) bad_addr++;
                pend_addr = int'(rd_addr);
                pend = 1;
                n_reads++;
            end
            er_done = 1'b0;
            if (er_cnt > 0) begin
                er_cnt--;
                if (er_cnt == 0) begin
                    er_done = 1'b1;
                    last_done_cyc = ncyc;
                end
            end
            if (er_start) begin
                if (int'(er_blk) != n_erases) bad_blk++;
                if (er_cnt != 0 || er_done) bad_overlap++;
                if (n_erases == 0) first_er_cyc = ncyc;
                n_erases++;
                er_cnt = 2 + int'(er_blk);
            end
            if (irq_mask) irq_cycles++;
            if (sci_re && sci_te && en_cyc < 0) en_cyc = ncyc;
            if (en_cyc >= 0 && !sci_re && !sci_te && fall_cyc < 0) fall_cyc = ncyc;
            if (txd_oe && txd_out && txd_cyc < 0) txd_cyc = ncyc;
            if (txd_cyc >= 0 && !(txd_oe && txd_out)) txd_drop = 1;
            if (branch_req) begin
                if (br_cyc < 0) br_cyc = ncyc;
                br_count++;
                if (branch_addr != 16'hE088) bad_target++;
                if (!done) done_drop = 1;
            end
            if (done) done_seen = 1;
            else if (done_seen) done_drop = 1;
            if (baud_keep) baud_seen = 1;
            else if (baud_seen) baud_drop = 1;
        end
    end

    task automatic do_reset(input bit bm);
        @(negedge clk); #1;
        rst = 1'b1;
        boot_mode = bm;
        repeat (3) @(negedge clk);
        #1;
        chk(!rd_valid && !er_start && !sci_re && !sci_te && !baud_keep && !txd_oe &&
            !txd_out && !irq_mask && !branch_req && !done, "R1", "outputs in reset",
            {rd_valid, er_start, sci_re, sci_te, baud_keep, txd_oe, txd_out,
             irq_mask, branch_req, done}, 0);
        rst = 1'b0;
    endtask

    task automatic run_case(input int zpos, input logic [DW-1:0] zval, input int mode);
        int exp_reads, refc, guard;
        for (int i = 0; i < NW; i++)
            fl[i] = (zpos >= 0 && i == zpos) ? zval : ((zpos >= 0 && i > zpos) ? 8'h5A : 8'hFF);
        rdy_mode = mode;
        do_reset(1'b1);
        guard = 0;
        while (!done_seen && guard < 2000) begin
            @(negedge clk); #1;
            guard++;
        end
        repeat (6) @(negedge clk);
        #1;
        chk(done_seen, "R10", "done reached", done_seen, 1);
        exp_reads = (zpos >= 0) ? zpos + 1 : NW;
        chk(n_reads == exp_reads, "R3", "read count", n_reads, exp_reads);
        chk(bad_addr == 0, "R3", "sequential addresses", bad_addr, 0);
        if (zpos < 0) begin
            chk(n_erases == 0, "R4", "erases on blank", n_erases, 0);
            refc = last_rsp_cyc;
        end else begin
            chk(n_erases == NB, "R5", "erase count", n_erases, NB);
            chk(bad_blk == 0 && bad_overlap == 0, "R5", "ascending, one at a time",
                bad_blk + bad_overlap, 0);
            chk(first_er_cyc == last_rsp_cyc + 1, "R5", "first erase cycle",
                first_er_cyc, last_rsp_cyc + 1);
            refc = last_done_cyc;
        end
        chk(irq_cycles == ((zpos < 0) ? 0 : last_done_cyc - first_er_cyc + 1), "R6",
            "mask cycles", irq_cycles,
            (zpos < 0) ? 0 : last_done_cyc - first_er_cyc + 1);
        chk(en_cyc > 0 && en_cyc <= 3, "R7", "enables raised", en_cyc, 2);
        chk(fall_cyc == refc + 2, "R7", "enables cleared cycle", fall_cyc, refc + 2);
        chk(baud_seen && !baud_drop, "R8", "baud kept", baud_drop, 0);
        chk(txd_cyc == refc + 3 && !txd_drop, "R9", "TxD high cycle", txd_cyc, refc + 3);
        chk(br_cyc == refc + 4 && br_count == 1, "R10", "branch cycle", br_cyc, refc + 4);
        chk(bad_target == 0 && !done_drop && done, "R10", "target and done held",
            bad_target + int'(done_drop), 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rdy_mode = 0;
        // R2: boot mode low
        do_reset(1'b0);
        repeat (40) @(negedge clk);
        #1;
        chk(n_reads == 0 && n_erases == 0, "R2", "no activity", n_reads + n_erases, 0);
        chk(!sci_re && !sci_te && br_count == 0 && !done, "R2", "no handoff",
            br_count + int'(done) + int'(sci_re), 0);
        for (int m = 0; m < 3; m++) begin
            run_case(-1, 8'hFF, m);
            for (int p = 0; p < NW; p++)
                run_case(p, 8'hFF ^ (8'h01 << ((p + m) % DW)), m);
        end
        run_case(NW - 1, 8'h00, 1);
        run_case(0, 8'h7F, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule